// File: doc/BRIEF.md
# Cascaded single-bit RAM pair

This block forms one deep single-bit memory out of two identical slices, each holding 2^SLICE_AW one-bit words. In its full-size setting (SLICE_AW = 15) each slice holds 32K x 1 and the pair holds 64K x 1. Cascading is defined only for this one-bit-wide, two-slice arrangement. The default of SLICE_AW is smaller so that the block stays light when elaborated with default parameters. The low address bits go to both slices in parallel. The most significant address bit picks the slice that accepts a write and the slice whose bit reaches the output.

Each slice has a position parameter: 0 marks the upper slice and 1 marks the lower slice. The lower slice's read bit runs over a dedicated cascade link into the upper slice. The lower slice's own cascade input is tied to a constant, and the upper slice's cascade output is not used at the pair's edge. The upper slice holds the words whose top address bit is 1, and the lower slice holds the words whose top address bit is 0. The upper slice's select mux drives the pair's output. That mux is controlled by the top address bit captured on the read edge.

The parameter OUT_REG adds a flip-flop after each slice's mux. This trades one cycle of latency for a shorter path from the array to the next logic stage. A single clock drives both slices. An asynchronous active-low reset is released synchronously inside the block.

Top module: `casc_bitram_pair`

## Requirements
- R1: A write (wr_en = 1) whose top address bit is 0 stores wr_bit in the lower slice, and a later read of the same full address returns that bit.
- R2: A write whose top address bit is 1 stores wr_bit in the upper slice only. Exactly one slice accepts each write, so the word at the same low address in the other slice keeps its value.
- R3: With OUT_REG = 0, the bit at the address presented on a rising edge appears on rd_bit just after that edge and holds for one cycle.
- R4: With OUT_REG = 1, the bit at the address presented on a rising edge appears on rd_bit just after the following rising edge. The slice select is delayed by the same amount.
- R5: A read of the address being written on the same edge returns the bit stored before the write (read-first).
- R6: While the reset is asserted, and until the synchronized release, rd_bit is 0.
- R7: Back-to-back accesses that alternate between the two halves at the same low address each return their own half's bit, with no cycle of mixing.
- R8: With wr_en = 0, wr_bit has no effect on either slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both slices |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | SLICE_AW+1 | Word address; the top bit selects the slice |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_bit | input | 1 | Data bit to write |
| rd_bit | output | 1 | Read bit from the upper slice's output stage |

## Verification
The hardest case to reach from the ports is a change of the top address bit on consecutive edges while the same low address is kept. In that case the captured select must switch between the cascade bit and the slice's own bit in the same cycle as the data. Directed sequences load opposite values into the two halves at one low address and then toggle the top bit every cycle. Two instances are built, one with the output stage and one without, and both receive the same stimulus. The random phase narrows the addresses to a small window so that read-during-write hits and half switches happen often.

// File: rtl/casc_bitram_pkg.sv
package casc_bitram_pkg;
  // Slice position encoding: upper slice is 0, lower slice is 1
  localparam int unsigned SLICE_UPPER = 0;
  localparam int unsigned SLICE_LOWER = 1;
  // Default slice address width (15 gives the full 32K x 1 slice)
  localparam int unsigned SLICE_AW_DEF = 10;
endpackage

// File: rtl/casc_rst_sync.sv
module casc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_q = sync_q;
endmodule

// File: rtl/casc_bitram_slice.sv
module casc_bitram_slice
  import casc_bitram_pkg::*;
#(
  parameter int unsigned AW      = SLICE_AW_DEF,
  parameter int unsigned POS     = SLICE_UPPER,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_lo,
  input  logic          slice_sel,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          casc_in,
  output logic          casc_out,
  output logic          dout
);
  localparam int unsigned DEPTH   = 1 << AW;
  localparam logic        OWN_SEL = (POS == SLICE_UPPER) ? 1'b1 : 1'b0;

  logic mem [DEPTH];

  logic wr_hit;
  logic rd_d, rd_q;
  logic sel_d, sel_q;
  logic mux_d;

  // next-state
  always_comb begin
    wr_hit = wr_en && (slice_sel == OWN_SEL);
    rd_d   = mem[addr_lo];
    sel_d  = slice_sel;
    mux_d  = (sel_q == OWN_SEL) ? rd_q : casc_in;
  end

  // array write (no reset on storage)
  always_ff @(posedge clk) begin
    if (wr_hit) begin
      mem[addr_lo] <= wr_bit;
    end
  end

  // read latch and captured select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      sel_q <= sel_d;
    end
  end

  assign casc_out = rd_q;

  generate
    if (OUT_REG) begin : g_oreg
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_q <= 1'b0;
        end else begin
          out_q <= mux_d;
        end
      end
      assign dout = out_q;
    end else begin : g_comb
      assign dout = mux_d;
    end
  endgenerate
endmodule

// File: rtl/casc_bitram_pair.sv
module casc_bitram_pair
  import casc_bitram_pkg::*;
#(
  parameter int unsigned SLICE_AW = SLICE_AW_DEF,
  parameter bit          OUT_REG  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLICE_AW:0] addr,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic              rd_bit
);
  localparam logic CASC_TIE = 1'b0;

  logic rst_q;
  logic lo_casc, up_casc;
  logic lo_dout;
  logic sel_d1, sel_d2;

  casc_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  casc_bitram_slice #(
    .AW      (SLICE_AW),
    .POS     (SLICE_LOWER),
    .OUT_REG (OUT_REG)
  ) u_lo (
    .clk       (clk),
    .rst_n     (rst_q),
    .addr_lo   (addr[SLICE_AW-1:0]),
    .slice_sel (addr[SLICE_AW]),
    .wr_en     (wr_en),
    .wr_bit    (wr_bit),
    .casc_in   (CASC_TIE),
    .casc_out  (lo_casc),
    .dout      (lo_dout)
  );

  casc_bitram_slice #(
    .AW      (SLICE_AW),
    .POS     (SLICE_UPPER),
    .OUT_REG (OUT_REG)
  ) u_up (
    .clk       (clk),
    .rst_n     (rst_q),
    .addr_lo   (addr[SLICE_AW-1:0]),
    .slice_sel (addr[SLICE_AW]),
    .wr_en     (wr_en),
    .wr_bit    (wr_bit),
    .casc_in   (lo_casc),
    .casc_out  (up_casc),
    .dout      (rd_bit)
  );

  // independent select tracker used by the checks below
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_d1 <= 1'b0;
      sel_d2 <= 1'b0;
    end else begin
      sel_d1 <= addr[SLICE_AW];
      sel_d2 <= sel_d1;
    end
  end

  // R6
  rst_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> (rd_bit == 1'b0));

  // R2
  one_slice_write_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $countones({u_lo.wr_hit, u_up.wr_hit}) == (wr_en ? 1 : 0));

  generate
    if (OUT_REG) begin : g_chk_reg
      // R4
      lower_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
        !sel_d2 |-> (rd_bit == lo_dout));
      // R4
      upper_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
        sel_d2 |-> (rd_bit == $past(up_casc)));
    end else begin : g_chk_comb
      // R3
      lower_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
        !sel_d1 |-> (rd_bit == lo_dout));
      // R3
      upper_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
        sel_d1 |-> (rd_bit == up_casc));
    end
  endgenerate
endmodule

// File: tb/casc_bitram_pair_test.sv
`timescale 1ns/1ps
module casc_bitram_pair_test;
  localparam int AW    = 10;
  localparam int WORDS = 1 << (AW + 1);
  localparam int HALF  = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic [AW:0]   addr;
  logic          wr_en;
  logic          wr_bit;
  logic          rd0, rd1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit model [WORDS];
  bit known [WORDS];

  // expected-value pipeline (stage 1 for latency 1, stage 2 for latency 2)
  bit    e1, e2, k1, k2;
  string t1, t2;

  casc_bitram_pair #(.SLICE_AW(AW), .OUT_REG(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_bit(wr_bit), .rd_bit(rd0));

  casc_bitram_pair #(.SLICE_AW(AW), .OUT_REG(1'b1)) uut_r (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_bit(wr_bit), .rd_bit(rd1));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit pattern_bit(int a);
    return bit'(((a * 37) ^ (a >> 3)) & 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one access: check outputs owed from earlier accesses, then drive new one
  task automatic access(int a, bit we, bit d, string tag);
    bit nexp;
    bit nk;
    @(negedge clk);
    if (k1) check({"R3 ", t1}, rd0, e1);
    if (k2) check({"R4 ", t2}, rd1, e2);
    addr   = (AW+1)'(a);
    wr_en  = we;
    wr_bit = d;
    nexp = model[a];
    nk   = known[a];
    if (we) begin
      model[a] = d;
      known[a] = 1'b1;
    end
    e2 = e1; k2 = k1; t2 = t1;
    e1 = nexp; k1 = nk; t1 = tag;
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_bit = 1'b0;
    e1 = 0; e2 = 0; k1 = 0; k2 = 0; t1 = ""; t2 = "";
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) begin
      model[i] = 1'b0;
      known[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R6 reset out (no oreg)", rd0, 1'b0);
    check("R6 reset out (oreg)", rd1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 sync release (no oreg)", rd0, 1'b0);
    check("R6 sync release (oreg)", rd1, 1'b0);
    repeat (3) @(negedge clk);

    // fill every word: R1 lower half, R2 upper half
    for (int a = 0; a < WORDS; a++)
      access(a, 1'b1, pattern_bit(a), (a < HALF) ? "R1 fill" : "R2 fill");

    // read back both halves
    for (int a = 0; a < WORDS; a += 7)
      access(a, 1'b0, 1'b0, (a < HALF) ? "R1 readback" : "R2 readback");

    // R2: opposite bits at one low address, other half untouched
    access(5, 1'b1, 1'b1, "R2 lower set");
    access(HALF + 5, 1'b1, 1'b0, "R2 upper clear");
    access(5, 1'b0, 1'b0, "R2 lower kept");
    access(HALF + 5, 1'b0, 1'b0, "R2 upper kept");

    // R7: alternate halves every cycle at the same low address
    for (int i = 0; i < 12; i++)
      access((i % 2 == 0) ? 5 : HALF + 5, 1'b0, 1'b0, "R7 alternate");
    access(0, 1'b1, 1'b0, "R7 corner lo0");
    access(HALF, 1'b1, 1'b1, "R7 corner hi0");
    access(HALF - 1, 1'b1, 1'b1, "R7 corner lomax");
    access(WORDS - 1, 1'b1, 1'b0, "R7 corner himax");
    access(0, 1'b0, 1'b0, "R7 corner lo0");
    access(HALF, 1'b0, 1'b0, "R7 corner hi0");
    access(HALF - 1, 1'b0, 1'b0, "R7 corner lomax");
    access(WORDS - 1, 1'b0, 1'b0, "R7 corner himax");

    // R5: read-during-write returns old bit, then new bit
    access(9, 1'b1, ~model[9], "R5 lower rdw");
    access(9, 1'b0, 1'b0, "R5 lower after");
    access(HALF + 9, 1'b1, ~model[HALF + 9], "R5 upper rdw");
    access(HALF + 9, 1'b0, 1'b0, "R5 upper after");

    // R8: data toggled with write disabled
    access(12, 1'b0, ~model[12], "R8 lower no write");
    access(12, 1'b0, 1'b0, "R8 lower unchanged");
    access(HALF + 12, 1'b0, ~model[HALF + 12], "R8 upper no write");
    access(HALF + 12, 1'b0, 1'b0, "R8 upper unchanged");

    // random phase in a narrow window spanning both halves
    for (int i = 0; i < 4000; i++) begin
      int  lo;
      int  a;
      lo = int'($urandom_range(0, 7));
      a  = ($urandom_range(0, 1) != 0) ? HALF + lo : lo;
      access(a, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
             (a < HALF) ? "R1 random" : "R2 random");
    end

    access(0, 1'b0, 1'b0, "flush");
    access(0, 1'b0, 1'b0, "flush");
    access(0, 1'b0, 1'b0, "flush");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule